// File: doc/BRIEF.md
# Serial-Input DAC Control Register

This block is the digital front end of an 8-bit voltage-output converter. A host writes 16-bit frames over a three-wire link: an active-low frame select, a serial clock and a data line. The block samples the data line on each falling edge of the serial clock. On the sixteenth falling edge it commits an 8-bit straight-binary code and a 2-bit power-down mode. It then drives the controls for the output stage: amplifier enable, a 1k pull-down, a 100k pull-down and high impedance.

The link pins are asynchronous to the block clock. They pass through synchronizers and are edge-detected on the block clock, which must run several times faster than the serial clock. A behavioural output `level_o` gives the ideal converter output, supply × code / 256, for a digital supply value applied at `vref_i`.

Frame layout, MSB first: bits 15:14 are ignored, bits 13:12 carry the mode, bits 11:4 carry the code, and bits 3:0 are ignored.

Top module: `sdac_ctrl`

## Requirements
- R1: A frame starts only when the frame select falls. Serial clock falling edges while select is high change nothing.
- R2: Data is sampled on falling serial clock edges, MSB first, into a 16-bit frame.
- R3: On the 16th falling edge, code_o takes frame bits 11:4 and mode_o takes frame bits 13:12. Bits 15:14 and 3:0 have no effect.
- R4: The mode selects the output stage as follows: 00 drives amp_en_o, 01 drives pull_1k_o, 10 drives pull_100k_o and 11 drives hiz_o. Exactly one of these four outputs is high at any time.
- R5: If select rises before the 16th falling edge, the partial frame is discarded and code_o and mode_o keep their values.
- R6: After a commit, further falling edges with select still low are ignored until select has risen and fallen again.
- R7: The commit occurs on the 16th edge without waiting for select to rise. Select may stay low after it.
- R8: After reset, code_o is 0, mode_o is 00 and amp_en_o is high.
- R9: level_o equals floor(vref_i × code_o / 256).
- R10: If select rises in the same block-clock cycle in which the 16th falling edge is detected, the frame still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsel_ni | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| vref_i | input | 12 | Supply value for the ideal output |
| code_o | output | 8 | Committed converter code |
| mode_o | output | 2 | Committed power-down mode |
| amp_en_o | output | 1 | Output amplifier enable |
| pull_1k_o | output | 1 | 1k pull-down to ground |
| pull_100k_o | output | 1 | 100k pull-down to ground |
| hiz_o | output | 1 | Output high-impedance |
| level_o | output | 12 | Ideal output value |

## Verification
Two functions can fall in the same synchronized cycle: the sixteenth falling edge, which commits the frame, and the rise of frame select, which aborts an open frame. The bench provokes the collision by switching both pins in the same instant. Because they pass through identical synchronizers, both events reach the frame engine together. The bench judges the outcome from code_o and mode_o: the collision counts as correct only if the frame committed. A partial frame aborted one edge earlier serves as the contrasting case, and there both outputs must keep their old values.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned TAIL_W  = 4;
  localparam int unsigned VREF_W  = 12;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN    = 2'b00,
    MODE_PD_1K  = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_PD_HIZ = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_n_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               commit_o,
  output logic               armed_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sel_q, sclk_q, armed_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               sel_fall, sclk_fall, take;

  assign sel_fall  = sel_q & ~sel_n_i;
  assign sclk_fall = sclk_q & ~sclk_i;
  // select fall restarts the frame and wins over a coincident clock edge
  assign take      = armed_q & sclk_fall & ~sel_fall;
  assign word_o    = {shreg_q[FRAME_W-2:0], sdi_i};
  assign commit_o  = take & (cnt_q == LAST);
  assign armed_o   = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b1;
      sclk_q  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sel_q  <= sel_n_i;
      sclk_q <= sclk_i;
      if (sel_fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (take) begin
        shreg_q <= word_o;
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (sel_n_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
  import sdac_pkg::*;
(
  input  logic [MODE_W-1:0]      mode_i,
  output logic [(1<<MODE_W)-1:0] term_o
);
  for (genvar m = 0; m < (1 << MODE_W); m++) begin : g_term
    assign term_o[m] = (mode_i == MODE_W'(m));
  end
endmodule

// File: rtl/sdac_level.sv
module sdac_level #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned VREF_W = 12
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [VREF_W-1:0] vref_i,
  output logic [VREF_W-1:0] level_o
);
  localparam int unsigned PROD_W = CODE_W + VREF_W;
  logic [PROD_W-1:0] prod;

  assign prod    = PROD_W'(vref_i) * PROD_W'(code_i);
  assign level_o = prod[PROD_W-1:CODE_W];
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsel_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [VREF_W-1:0] vref_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              amp_en_o,
  output logic              pull_1k_o,
  output logic              pull_100k_o,
  output logic              hiz_o,
  output logic [VREF_W-1:0] level_o
);
  localparam int unsigned CODE_LSB = TAIL_W;
  localparam int unsigned MODE_LSB = TAIL_W + CODE_W;

  logic [2:0]          pins_s;
  logic                commit, armed;
  logic [FRAME_W-1:0]  word;
  logic [CODE_W-1:0]   code_q;
  logic [MODE_W-1:0]   mode_q;
  logic [(1<<MODE_W)-1:0] term;

  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sclk_i, fsel_ni}),
    .q_o   (pins_s)
  );

  sdac_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_n_i (pins_s[0]),
    .sclk_i  (pins_s[1]),
    .sdi_i   (pins_s[2]),
    .commit_o(commit),
    .armed_o (armed),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mode_q <= MODE_RUN;
    end else if (commit) begin
      code_q <= word[CODE_LSB +: CODE_W];
      mode_q <= word[MODE_LSB +: MODE_W];
    end
  end

  sdac_decode u_decode (
    .mode_i(mode_q),
    .term_o(term)
  );

  sdac_level #(.CODE_W(CODE_W), .VREF_W(VREF_W)) u_level (
    .code_i (code_q),
    .vref_i (vref_i),
    .level_o(level_o)
  );

  assign code_o      = code_q;
  assign mode_o      = mode_q;
  assign amp_en_o    = term[MODE_RUN];
  assign pull_1k_o   = term[MODE_PD_1K];
  assign pull_100k_o = term[MODE_PD_100K];
  assign hiz_o       = term[MODE_PD_HIZ];
endmodule

// File: rtl/sdac_ctrl_chk.sv
module sdac_ctrl_chk
  import sdac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              amp_en_o,
  input logic              pull_1k_o,
  input logic              pull_100k_o,
  input logic              hiz_o,
  input logic [VREF_W-1:0] vref_i,
  input logic [VREF_W-1:0] level_o,
  input logic              commit_i,
  input logic              armed_i
);
  assert_term_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({amp_en_o, pull_1k_o, pull_100k_o, hiz_o}) == 1);

  assert_amp_only_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_en_o |-> mode_o == MODE_RUN);

  assert_hold_without_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(code_o) && $stable(mode_o));

  assert_commit_in_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> armed_i);

  assert_disarm_after_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !armed_i);

  assert_level_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= vref_i);

  assert_level_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o == '0 |-> level_o == '0);
endmodule

bind sdac_ctrl sdac_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_o     (code_o),
  .mode_o     (mode_o),
  .amp_en_o   (amp_en_o),
  .pull_1k_o  (pull_1k_o),
  .pull_100k_o(pull_100k_o),
  .hiz_o      (hiz_o),
  .vref_i     (vref_i),
  .level_o    (level_o),
  .commit_i   (commit),
  .armed_i    (armed)
);

// File: tb/sdac_ctrl_bench.sv
module sdac_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdi = 1'b0;
  logic [11:0] vref = 12'd4095;
  logic [7:0]  code;
  logic [1:0]  mode;
  logic        amp_en, p1k, p100k, hiz;
  logic [11:0] level;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_code = 8'd0;
  logic [1:0] exp_mode = 2'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdac_ctrl u_sdac_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fsel_ni(fsel_n), .sclk_i(sclk), .sdi_i(sdi),
    .vref_i(vref), .code_o(code), .mode_o(mode), .amp_en_o(amp_en),
    .pull_1k_o(p1k), .pull_100k_o(p100k), .hiz_o(hiz), .level_o(level)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one falling serial edge carrying bit b; half period 5 block cycles
  task automatic bit_out(input logic b);
    sdi = b;
    wait_cyc(5);
    sclk = 1'b0;
    wait_cyc(5);
    sclk = 1'b1;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit rise);
    fsel_n = 1'b0;
    wait_cyc(5);
    for (int i = 15; i > 15 - nbits; i--) bit_out(w[i]);
    if (rise) begin
      wait_cyc(5);
      fsel_n = 1'b1;
    end
    wait_cyc(8);
  endtask

  task automatic check_all(input string req);
    chk({req, " code"}, int'(code), int'(exp_code));
    chk({req, " mode"}, int'(mode), int'(exp_mode));
    chk({req, " term"}, int'({hiz, p100k, p1k, amp_en}), 1 << exp_mode);
    chk({req, " level"}, int'(level), (int'(vref) * int'(exp_code)) / 256);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] junk_hi, input logic [1:0] m,
                                     input logic [7:0] c, input logic [3:0] junk_lo);
    return {junk_hi, m, c, junk_lo};
  endfunction

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    // R8 reset state
    chk("R8 code", int'(code), 0);
    chk("R8 mode", int'(mode), 0);
    chk("R8 amp_en", int'(amp_en), 1);
    check_all("R8");

    // R2 R3 R4 R9 sweep of all codes, modes cycling, junk bits varied
    for (int c = 0; c < 256; c++) begin
      vref = 12'(4095 - c * 13);
      exp_code = 8'(c);
      exp_mode = 2'(c * 7);
      frame(mk(2'(c), exp_mode, exp_code, 4'(~c)), 16, 1'b1);
      check_all("R3");
    end

    // R9 extra supply values at full-scale code
    exp_code = 8'hFF; exp_mode = 2'd0;
    frame(mk(2'b11, 2'b00, 8'hFF, 4'hF), 16, 1'b1);
    for (int v = 0; v < 4096; v += 455) begin
      vref = 12'(v);
      wait_cyc(2);
      chk("R9 level", int'(level), (v * 255) / 256);
    end
    vref = 12'd3000;

    // R1 edges with select high are ignored
    sdi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wait_cyc(5); sclk = 1'b0; wait_cyc(5); sclk = 1'b1;
    end
    wait_cyc(8);
    check_all("R1");
    exp_code = 8'h5A; exp_mode = 2'd2;
    frame(mk(2'b00, 2'd2, 8'h5A, 4'h0), 16, 1'b1);
    check_all("R1 after fall");

    // R5 partial frame discarded
    frame(mk(2'b00, 2'd1, 8'hC3, 4'h0), 15, 1'b1);
    check_all("R5");
    frame(mk(2'b00, 2'd3, 8'h11, 4'h0), 6, 1'b1);
    check_all("R5 short");

    // R7 commit with select still low, then R6 extra edges ignored
    exp_code = 8'h3C; exp_mode = 2'd1;
    frame(mk(2'b00, 2'd1, 8'h3C, 4'h0), 16, 1'b0);
    check_all("R7");
    for (int i = 0; i < 16; i++) bit_out(1'b1);
    wait_cyc(8);
    check_all("R6");
    fsel_n = 1'b1;
    wait_cyc(5);
    exp_code = 8'h81; exp_mode = 2'd3;
    frame(mk(2'b00, 2'd3, 8'h81, 4'h0), 16, 1'b1);
    check_all("R6 next frame");

    // R10 select rises together with the 16th edge
    begin
      logic [15:0] w;
      w = mk(2'b10, 2'd0, 8'hE7, 4'h5);
      fsel_n = 1'b0;
      wait_cyc(5);
      for (int i = 15; i > 0; i--) bit_out(w[i]);
      sdi = w[0];
      wait_cyc(5);
      sclk = 1'b0;
      fsel_n = 1'b1;
      wait_cyc(5);
      sclk = 1'b1;
      wait_cyc(8);
      exp_code = 8'hE7; exp_mode = 2'd0;
      check_all("R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule